// File: doc/BRIEF.md
# Modem Handshake Control and Status Registers

This block is the modem-line register pair of one serial channel. A host port writes an 8-bit control register that drives the active-low DTR and RTS pins. The same register enables the interrupt output driver, turns on the FIFO-ready register, selects the Xon-any function, opens access to an extra register pair and picks the input clock divider. The host reads an 8-bit status register. It holds the present, active-high level of the CTS, DSR, RI and CD inputs in its upper nibble and four sticky change flags in its lower nibble. Reading the status register clears the flags.

A local loopback mode feeds the control bits back into the status register in place of the pins. In this mode the serial transmit stream is routed to the serial receive path. The external DTR, RTS and TXD pins are parked at their inactive levels.

The control logic is a three-state machine. `MD_BOOT` is the single cycle after reset release: it loads the divider bit from the inverted clock-select pin, discards any write and always moves to `MD_NORMAL`. `MD_NORMAL` moves to `MD_LOOP` on a write with the loopback bit set. `MD_LOOP` moves back to `MD_NORMAL` on a write with the loopback bit clear. Any other write keeps the current state.

Top module: `modem_hs_regs`

## Requirements
- R1: While reset is held and at reset release, control bits 6:0 are 0, DTR and RTS pins are high, the interrupt enable is 0, and status reads 0x00 when all modem pins are high. The first clock edge after release loads control bit 7 with the inverse of `clksel_pin` and discards any write present at that edge.
- R2: Outside loopback, control bit 0 set drives `dtr_n` low, and bit 1 set drives `rts_n` low when automatic RTS is off. A clear bit drives the pin high.
- R3: Outside loopback with `auto_rts_en` = 1, `rts_n` equals `flow_rts_n` regardless of control bit 1.
- R4: A write always updates control bits 4:0. Control bits 7:5 are updated only when `enh_wr_en` = 1 and otherwise keep their value.
- R5: The enable outputs mirror control bits: bit 2 drives `fifo_rdy_en`, bit 3 drives `irq_oe`, bit 5 drives `xon_any_en`, bit 6 drives `ext_reg_en`, and bit 7 drives `clk_div4` (1 = divide by four).
- R6: Outside loopback, status bits 4, 5, 6 and 7 are the inverse of `cts_n`, `dsr_n`, `ri_n` and `cd_n`. Each pin passes two synchroniser stages, so the status bit changes two clock edges after the pin.
- R7: In loopback (control bit 4 = 1), status bits 4, 5, 6 and 7 equal control bits 1, 0, 2 and 3, and the modem pins have no effect. `dtr_n`, `rts_n` and `txd` are held at 1.
- R8: Outside loopback, `txd` follows `ser_tx` and `ser_rx` follows `rxd`. In loopback, `ser_rx` follows `ser_tx`.
- R9: Status bits 0, 1 and 3 set on either edge of the CTS, DSR and CD levels, one edge after the level bit changes. They stay set until a status read (`rd_en` = 1 at a clock edge) clears them.
- R10: Status bit 2 sets only when the RI level bit falls from 1 to 0, which is the RI pin rising. A 0-to-1 level change leaves it clear.
- R11: In loopback, the change flags follow the looped sources. Bit 2 sets when control bit 2 goes from 1 to 0, and not when it goes from 0 to 1.
- R12: A change that happens at the same edge as a status read leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clksel_pin | input | 1 | Clock-select strap, inverted into control bit 7 at reset release |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| enh_wr_en | input | 1 | Write enable for control bits 7:5 |
| rd_en | input | 1 | Status read strobe, clears change flags |
| ctl_rdata | output | 8 | Control register contents |
| stat_rdata | output | 8 | Status register: levels [7:4], change flags [3:0] |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| cd_n | input | 1 | Carrier-detect pin, active low |
| auto_rts_en | input | 1 | Hardware flow control owns RTS |
| flow_rts_n | input | 1 | RTS level from hardware flow control |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| irq_oe | output | 1 | Interrupt output driver enable |
| fifo_rdy_en | output | 1 | FIFO-ready register enable |
| xon_any_en | output | 1 | Xon-any function enable |
| ext_reg_en | output | 1 | Extra register pair access enable |
| clk_div4 | output | 1 | Input clock divide-by-four select |
| ser_tx | input | 1 | Serial transmit data from the serializer |
| txd | output | 1 | Serial transmit pin |
| rxd | input | 1 | Serial receive pin |
| ser_rx | output | 1 | Serial receive data to the deserializer |

## Verification
A control write sampled at edge k shows on `ctl_rdata`, the DTR/RTS pins, the enable outputs and the loopback levels at the falling edge after k. A loopback change flag follows one edge later. A modem pin change reaches the status level after two edges and its flag after three. A read clears flags at its own edge. The serial paths have no register at all. Every input is driven on a falling edge, and the bench steps an exact number of rising edges before it samples on the next falling edge. Each check therefore lands on the first cycle in which the result is due. Where a test needs it, the bench also samples one cycle earlier to confirm that the result has not arrived too soon.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int REG_W       = 8;
    localparam int LINES       = 4;
    localparam int SYNC_STAGES = 2;

    // control register bit positions
    localparam int B_DTR  = 0;
    localparam int B_RTS  = 1;
    localparam int B_FRDY = 2;
    localparam int B_IRQ  = 3;
    localparam int B_LOOP = 4;
    localparam int B_XON  = 5;
    localparam int B_XREG = 6;
    localparam int B_DIV  = 7;
    localparam int GATED_LSB = 5;

    // modem line index inside the level / flag nibbles
    localparam int L_CTS = 0;
    localparam int L_DSR = 1;
    localparam int L_RI  = 2;
    localparam int L_CD  = 3;
    localparam int LVL_LSB = LINES;

    typedef enum logic [1:0] {
        MD_BOOT   = 2'd0,
        MD_NORMAL = 2'd1,
        MD_LOOP   = 2'd2
    } mode_e;

    // crossed mapping of control bits onto line levels in loopback
    function automatic logic [LINES-1:0] loop_src(input logic [REG_W-1:0] c);
        logic [LINES-1:0] s;
        s[L_CTS] = c[B_RTS];
        s[L_DSR] = c[B_DTR];
        s[L_RI]  = c[B_FRDY];
        s[L_CD]  = c[B_IRQ];
        return s;
    endfunction

    // write merge: low bits always, gated bits only with the enhanced enable
    function automatic logic [REG_W-1:0] merge_wr(input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] wd,
                                                  input logic             enh);
        logic [REG_W-1:0] r;
        for (int b = 0; b < REG_W; b++) begin
            r[b] = (b < GATED_LSB || enh) ? wd[b] : cur[b];
        end
        return r;
    endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_ctl_fsm.sv
module mdm_ctl_fsm
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clksel_pin,
    input  logic             wr_en,
    input  logic             enh_wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctl_q,
    output mode_e            mode_q
);
    mode_e            mode_d;
    logic [REG_W-1:0] ctl_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MD_BOOT;
        else        mode_q <= mode_d;
    end

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // next state and next register contents
    always_comb begin
        mode_d = mode_q;
        ctl_d  = ctl_q;
        unique case (mode_q)
            MD_BOOT: begin
                ctl_d[B_DIV] = ~clksel_pin;
                mode_d       = MD_NORMAL;
            end
            MD_NORMAL: begin
                if (wr_en) begin
                    ctl_d = merge_wr(ctl_q, wr_data, enh_wr_en);
                    if (wr_data[B_LOOP]) mode_d = MD_LOOP;
                end
            end
            MD_LOOP: begin
                if (wr_en) begin
                    ctl_d = merge_wr(ctl_q, wr_data, enh_wr_en);
                    if (!wr_data[B_LOOP]) mode_d = MD_NORMAL;
                end
            end
            default: mode_d = MD_BOOT;
        endcase
    end
endmodule

// File: rtl/mdm_stat.sv
module mdm_stat #(
    parameter int N         = 4,
    parameter int FALL_ONLY = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] flags_q
);
    logic [N-1:0] prev_q;
    logic [N-1:0] evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar g = 0; g < N; g++) begin : g_evt
        if (g == FALL_ONLY) begin : g_fall
            assign evt[g] = prev_q[g] & ~lvl[g];
        end else begin : g_any
            assign evt[g] = prev_q[g] ^ lvl[g];
        end
    end

    // a new event outranks the clearing read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~{N{rd_en}}) | evt;
    end
endmodule

// File: rtl/modem_hs_regs.sv
module modem_hs_regs
    import mdm_pkg::*;
#(
    parameter int SYNC_N = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clksel_pin,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             enh_wr_en,
    input  logic             rd_en,
    output logic [REG_W-1:0] ctl_rdata,
    output logic [REG_W-1:0] stat_rdata,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             ri_n,
    input  logic             cd_n,
    input  logic             auto_rts_en,
    input  logic             flow_rts_n,
    output logic             dtr_n,
    output logic             rts_n,
    output logic             irq_oe,
    output logic             fifo_rdy_en,
    output logic             xon_any_en,
    output logic             ext_reg_en,
    output logic             clk_div4,
    input  logic             ser_tx,
    output logic             txd,
    input  logic             rxd,
    output logic             ser_rx
);
    logic [REG_W-1:0] ctl_q;
    mode_e            mode_q;
    logic [LINES-1:0] pins_n;
    logic [LINES-1:0] pins_sync_n;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] flags;

    mdm_ctl_fsm u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clksel_pin (clksel_pin),
        .wr_en      (wr_en),
        .enh_wr_en  (enh_wr_en),
        .wr_data    (wr_data),
        .ctl_q      (ctl_q),
        .mode_q     (mode_q)
    );

    always_comb begin
        pins_n        = '1;
        pins_n[L_CTS] = cts_n;
        pins_n[L_DSR] = dsr_n;
        pins_n[L_RI]  = ri_n;
        pins_n[L_CD]  = cd_n;
    end

    mdm_sync #(
        .W       (LINES),
        .STAGES  (SYNC_N),
        .RST_VAL ({LINES{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_n),
        .q     (pins_sync_n)
    );

    mdm_stat #(
        .N         (LINES),
        .FALL_ONLY (L_RI)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .lvl     (lvl),
        .flags_q (flags)
    );

    // outputs decoded from the state
    always_comb begin
        lvl    = ~pins_sync_n;
        dtr_n  = 1'b1;
        rts_n  = 1'b1;
        txd    = 1'b1;
        ser_rx = rxd;
        unique case (mode_q)
            MD_LOOP: begin
                lvl    = loop_src(ctl_q);
                ser_rx = ser_tx;
            end
            MD_BOOT, MD_NORMAL: begin
                dtr_n = ~ctl_q[B_DTR];
                rts_n = auto_rts_en ? flow_rts_n : ~ctl_q[B_RTS];
                txd   = ser_tx;
            end
            default: begin
                lvl = '0;
            end
        endcase
    end

    assign fifo_rdy_en = ctl_q[B_FRDY];
    assign irq_oe      = ctl_q[B_IRQ];
    assign xon_any_en  = ctl_q[B_XON];
    assign ext_reg_en  = ctl_q[B_XREG];
    assign clk_div4    = ctl_q[B_DIV];
    assign ctl_rdata   = ctl_q;
    assign stat_rdata  = {lvl, flags};
endmodule

// File: rtl/mdm_regs_chk.sv
module mdm_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       enh_wr_en,
    input logic       rd_en,
    input logic [7:0] ctl_rdata,
    input logic [7:0] stat_rdata,
    input logic       auto_rts_en,
    input logic       flow_rts_n,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       ser_tx,
    input logic       txd,
    input logic       rxd,
    input logic       ser_rx
);
    logic booted_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) booted_q <= 1'b0;
        else        booted_q <= 1'b1;
    end

    assert_low_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && booted_q) |=> (ctl_rdata[4:0] == $past(wr_data[4:0])));

    assert_gated_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !enh_wr_en && booted_q) |=> $stable(ctl_rdata[7:5]));

    assert_auto_rts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && !ctl_rdata[4]) |-> (rts_n == flow_rts_n));

    assert_loop_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4] |-> (dtr_n && rts_n && txd && (ser_rx == ser_tx)));

    assert_loop_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4] |-> (stat_rdata[7:4] ==
                          {ctl_rdata[3], ctl_rdata[2], ctl_rdata[0], ctl_rdata[1]}));

    assert_serial_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[4] |-> ((ser_rx == rxd) && (txd == ser_tx)));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ((stat_rdata[3:0] & $past(stat_rdata[3:0])) == $past(stat_rdata[3:0])));
endmodule

bind modem_hs_regs mdm_regs_chk u_mdm_regs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .enh_wr_en   (enh_wr_en),
    .rd_en       (rd_en),
    .ctl_rdata   (ctl_rdata),
    .stat_rdata  (stat_rdata),
    .auto_rts_en (auto_rts_en),
    .flow_rts_n  (flow_rts_n),
    .dtr_n       (dtr_n),
    .rts_n       (rts_n),
    .ser_tx      (ser_tx),
    .txd         (txd),
    .rxd         (rxd),
    .ser_rx      (ser_rx)
);

// File: tb/test_modem_hs_regs.sv
module test_modem_hs_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clksel_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       enh_wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] ctl_rdata, stat_rdata;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
    logic       auto_rts_en = 1'b0, flow_rts_n = 1'b1;
    logic       dtr_n, rts_n, irq_oe, fifo_rdy_en, xon_any_en, ext_reg_en, clk_div4;
    logic       ser_tx = 1'b1, txd, rxd = 1'b1, ser_rx;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    modem_hs_regs i_modem_hs_regs (
        .clk(clk), .rst_n(rst_n), .clksel_pin(clksel_pin),
        .wr_en(wr_en), .wr_data(wr_data), .enh_wr_en(enh_wr_en), .rd_en(rd_en),
        .ctl_rdata(ctl_rdata), .stat_rdata(stat_rdata),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
        .auto_rts_en(auto_rts_en), .flow_rts_n(flow_rts_n),
        .dtr_n(dtr_n), .rts_n(rts_n), .irq_oe(irq_oe), .fifo_rdy_en(fifo_rdy_en),
        .xon_any_en(xon_any_en), .ext_reg_en(ext_reg_en), .clk_div4(clk_div4),
        .ser_tx(ser_tx), .txd(txd), .rxd(rxd), .ser_rx(ser_rx)
    );

    typedef struct packed {
        logic [7:0] wdata;
        logic       enh;
        logic       auto_rts;
        logic       flow_n;
        logic [7:0] exp_ctl;
        logic       exp_dtr_n;
        logic       exp_rts_n;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{8'h03, 1'b0, 1'b0, 1'b1, 8'h83, 1'b0, 1'b0},
        '{8'h00, 1'b0, 1'b0, 1'b1, 8'h80, 1'b1, 1'b1},
        '{8'h01, 1'b0, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1},
        '{8'h02, 1'b0, 1'b1, 1'b1, 8'h82, 1'b1, 1'b1},
        '{8'h00, 1'b0, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0},
        '{8'h6C, 1'b0, 1'b0, 1'b1, 8'h8C, 1'b1, 1'b1},
        '{8'h6C, 1'b1, 1'b0, 1'b1, 8'h6C, 1'b1, 1'b1},
        '{8'h0F, 1'b0, 1'b0, 1'b1, 8'h6F, 1'b0, 1'b0},
        '{8'h80, 1'b1, 1'b0, 1'b1, 8'h80, 1'b1, 1'b1},
        '{8'hE3, 1'b0, 1'b0, 1'b1, 8'h83, 1'b0, 1'b0},
        '{8'h22, 1'b1, 1'b0, 1'b1, 8'h22, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d, input logic enh);
        wr_data   = d;
        enh_wr_en = enh;
        wr_en     = 1'b1;
        tick(1);
        wr_en     = 1'b0;
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state, with a write held across the boot edge
        wr_data = 8'h1F; enh_wr_en = 1'b1; wr_en = 1'b1;
        tick(3);
        chk("R1 ctl in reset", ctl_rdata, 8'h00);
        chk("R1 pins in reset", {6'b0, dtr_n, rts_n}, 8'h03);
        rst_n = 1'b1;
        tick(1);
        wr_en = 1'b0;
        chk("R1 ctl after boot", ctl_rdata, 8'h80);
        chk("R1 status after boot", stat_rdata, 8'h00);
        chk("R1 irq enable", {7'b0, irq_oe}, 8'h00);

        // R2 R3 R4 R5: vector table
        for (int v = 0; v < NVEC; v++) begin
            auto_rts_en = VECS[v].auto_rts;
            flow_rts_n  = VECS[v].flow_n;
            do_write(VECS[v].wdata, VECS[v].enh);
            chk($sformatf("R4 ctl vec%0d", v), ctl_rdata, VECS[v].exp_ctl);
            chk($sformatf("R2 R3 pins vec%0d", v), {6'b0, dtr_n, rts_n},
                {6'b0, VECS[v].exp_dtr_n, VECS[v].exp_rts_n});
            chk($sformatf("R5 enables vec%0d", v),
                {3'b0, clk_div4, ext_reg_en, xon_any_en, irq_oe, fifo_rdy_en},
                {3'b0, VECS[v].exp_ctl[7], VECS[v].exp_ctl[6], VECS[v].exp_ctl[5],
                 VECS[v].exp_ctl[3], VECS[v].exp_ctl[2]});
        end
        auto_rts_en = 1'b0;
        do_write(8'h00, 1'b1);

        // R6 R9: CTS level latency and change flag
        cts_n = 1'b0;
        tick(1);
        chk("R6 cts not yet", stat_rdata, 8'h00);
        tick(1);
        chk("R6 cts level", stat_rdata, 8'h10);
        tick(1);
        chk("R9 cts flag", stat_rdata, 8'h11);
        do_read();
        chk("R9 read clears", stat_rdata, 8'h10);
        cts_n = 1'b1;
        tick(3);
        chk("R9 cts release flag", stat_rdata, 8'h01);
        do_read();

        // R10: RI flag only on pin rising
        ri_n = 1'b0;
        tick(3);
        chk("R10 ri active no flag", stat_rdata, 8'h40);
        ri_n = 1'b1;
        tick(3);
        chk("R10 ri release flag", stat_rdata, 8'h04);
        do_read();

        // R6 R9: DSR and CD together
        dsr_n = 1'b0; cd_n = 1'b0;
        tick(3);
        chk("R9 dsr cd flags", stat_rdata, 8'hAA);
        do_read();
        chk("R9 dsr cd cleared", stat_rdata, 8'hA0);
        dsr_n = 1'b1; cd_n = 1'b1;
        tick(3);
        chk("R9 dsr cd release", stat_rdata, 8'h0A);
        do_read();
        chk("R9 all clear", stat_rdata, 8'h00);

        // R8: serial pass-through
        ser_tx = 1'b0; rxd = 1'b1;
        #1;
        chk("R8 serial a", {6'b0, txd, ser_rx}, 8'h01);
        ser_tx = 1'b1; rxd = 1'b0;
        #1;
        chk("R8 serial b", {6'b0, txd, ser_rx}, 8'h02);
        rxd = 1'b1;

        // R7 R11: loopback
        do_write(8'h10, 1'b1);
        chk("R7 loop entry", stat_rdata, 8'h00);
        do_write(8'h13, 1'b1);
        ser_tx = 1'b0;
        #1;
        chk("R7 loop levels", stat_rdata, 8'h30);
        chk("R7 loop park", {5'b0, dtr_n, rts_n, txd}, 8'h07);
        chk("R8 loop serial", {7'b0, ser_rx}, 8'h00);
        ser_tx = 1'b1;
        tick(1);
        chk("R11 loop flags", stat_rdata, 8'h33);
        do_read();
        do_write(8'h1C, 1'b1);
        chk("R7 crossed map", stat_rdata, 8'hC0);
        tick(1);
        chk("R11 ri src rise no flag", stat_rdata, 8'hCB);
        do_read();
        cts_n = 1'b0; dsr_n = 1'b0;
        tick(3);
        chk("R7 pins ignored", stat_rdata, 8'hC0);
        cts_n = 1'b1; dsr_n = 1'b1;
        tick(3);
        do_write(8'h18, 1'b1);
        tick(1);
        chk("R11 ri src fall flag", stat_rdata, 8'h84);
        do_read();

        // R12: change at the same edge as a read
        wr_data = 8'h10; enh_wr_en = 1'b1; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0; rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
        chk("R12 event beats read", stat_rdata, 8'h08);
        do_read();
        chk("R12 later read clears", stat_rdata, 8'h00);

        do_write(8'h00, 1'b1);
        tick(1);
        chk("R7 loop exit", stat_rdata, 8'h00);

        // R1: reset with the strap high
        clksel_pin = 1'b1;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        chk("R1 strap high ctl", ctl_rdata, 8'h00);
        chk("R1 strap high div", {7'b0, clk_div4}, 8'h00);

        summary();
        $finish;
    end
endmodule